// File: doc/BRIEF.md
# I2C SDA Hold Time Generator

This block sits between an I2C controller's protocol engine and its SDA driver. It delays each new SDA value so that the value changes only a programmed number of controller clock cycles after the SCL line has been seen to fall. This keeps the data line stable through the hold window that follows every clock falling edge. There is one hold count for when the controller transmits and a second count for when it receives. A role input selects between them.

SCL comes into the block as a raw level and passes through a two-stage synchronizer before any edge is detected. The block also times each SCL low phase in controller clock cycles. The transmit hold may not exceed the most recently measured low phase minus two cycles. When the programmed transmit hold is larger than that, the block applies the limit in its place and raises an error flag.

The two hold counts live in one 32-bit configuration word. It is written with a strobe and can be read back at any time.

Top module: `sda_hold_gen`

## Requirements
- R1: The configuration word holds the transmit hold count in bits 15:0 and the receive hold count in bits 23:16, and reads back on `cfg_o`. After reset it reads 0x0000_0001, which is transmit hold 1 and receive hold 0. A write with `cfg_we_i` high takes effect after that clock edge, and the word is unchanged on every other cycle.
- R2: Bits 31:24 of a write are ignored and always read back as zero.
- R3: When `is_tx_i` is 1, a new `sda_next_i` value reaches `sda_o` exactly H cycles after the falling SCL edge is detected, where H is the effective transmit hold. The falling edge is detected two cycles after `scl_i` goes low, because of the two-flop synchronizer.
- R4: When `is_tx_i` is 0, the receive hold count from bits 23:16 sets the delay, with the same timing as R3.
- R5: A selected hold of 0 updates `sda_o` on the clock edge right after the falling edge is detected.
- R6: `sda_o` does not change while the synchronized SCL is high, and it does not change during the hold window.
- R7: Once the hold window has expired and while the synchronized SCL stays low, `sda_o` follows `sda_next_i` with one cycle of delay.
- R8: The block measures the length L of the most recent SCL low phase in controller cycles. If the transmit hold is greater than L-2, the effective transmit hold becomes L-2 and `cfg_err_o` is 1.
- R9: A transmit hold equal to L-2 is applied unchanged, and `cfg_err_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL line level |
| sda_next_i | input | 1 | Next SDA value from the protocol engine |
| is_tx_i | input | 1 | 1 = transmitter role, 0 = receiver role |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_i | input | 32 | Configuration write data |
| cfg_o | output | 32 | Configuration readback |
| sda_o | output | 1 | Hold-delayed SDA drive value |
| cfg_err_o | output | 1 | Transmit hold exceeds the SCL low limit |

## Verification
The assertions are checked on every cycle and cover these properties:
- `sda_o` stays frozen while synchronized SCL is high.
- A zero hold passes the next value straight through after the falling edge.
- The effective transmit hold never goes above the measured limit once a low phase has been timed.
- The configuration word changes only on a write.

Only the bench scenarios can show the following:
- The exact cycle on which SDA moves for each hold count and each role.
- Reserved bits being dropped on a write.
- The clamp boundary, where L-2 is accepted and L-1 raises the error flag.

// File: rtl/sda_hold_pkg.sv
package sda_hold_pkg;
  localparam int unsigned CFG_W = 32;
  localparam int unsigned TX_W  = 16;
  localparam int unsigned RX_W  = 8;
  localparam int unsigned RSV_W = CFG_W - TX_W - RX_W;
  localparam int unsigned LEN_W = TX_W;

  typedef struct packed {
    logic [RSV_W-1:0] rsvd;
    logic [RX_W-1:0]  rx_hold;
    logic [TX_W-1:0]  tx_hold;
  } hold_cfg_t;

  localparam logic [TX_W-1:0] TX_RST = TX_W'(1);
  localparam logic [RX_W-1:0] RX_RST = '0;
endpackage

// File: rtl/sda_scl_sync.sv
module sda_scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic scl_s_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], scl_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign scl_s_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~scl_s_o;
  assign rise_o  = ~prev_q & scl_s_o;
endmodule

// File: rtl/sda_low_meter.sv
module sda_low_meter
  import sda_hold_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic [LEN_W-1:0] low_len_o,
  output logic             valid_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      low_len_o <= '0;
      valid_o   <= 1'b0;
    end else begin
      if (fall_i) cnt_q <= LEN_W'(1);
      else if (!scl_s_i && cnt_q != '1) cnt_q <= cnt_q + LEN_W'(1);
      if (rise_i) begin
        low_len_o <= cnt_q;
        valid_o   <= 1'b1;
      end
    end
  end

  assert_meas_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> valid_o);
endmodule

// File: rtl/sda_hold_sel.sv
module sda_hold_sel
  import sda_hold_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             is_tx_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic             valid_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [TX_W-1:0]  hold_o,
  output logic             err_o
);
  hold_cfg_t        wr;
  logic [TX_W-1:0]  tx_q;
  logic [RX_W-1:0]  rx_q;
  logic [LEN_W-1:0] limit;
  logic             over;

  assign wr = hold_cfg_t'(cfg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= TX_RST;
      rx_q <= RX_RST;
    end else if (cfg_we_i) begin
      tx_q <= wr.tx_hold;
      rx_q <= wr.rx_hold;
    end
  end

  always_comb begin
    limit = (low_len_i >= LEN_W'(2)) ? low_len_i - LEN_W'(2) : '0;
    over  = valid_i && (tx_q > limit);
    if (!is_tx_i)  hold_o = TX_W'(rx_q);
    else if (over) hold_o = limit;
    else           hold_o = tx_q;
  end

  assign err_o = over;
  assign cfg_o = CFG_W'({{RSV_W{1'b0}}, rx_q, tx_q});

  assert_clamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_tx_i) |-> (hold_o <= limit));
  assert_cfg_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_o));
endmodule

// File: rtl/sda_hold_ctrl.sv
module sda_hold_ctrl
  import sda_hold_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_s_i,
  input  logic            fall_i,
  input  logic            rise_i,
  input  logic [TX_W-1:0] hold_i,
  input  logic            sda_next_i,
  output logic            sda_o
);
  logic [TX_W-1:0] cnt_q;
  logic            done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      sda_o  <= 1'b1;
    end else if (fall_i) begin
      if (hold_i == '0) begin
        sda_o  <= sda_next_i;
        done_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= hold_i;
        done_q <= 1'b0;
      end
    end else if (rise_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TX_W'(1);
      if (cnt_q == TX_W'(1)) begin
        sda_o  <= sda_next_i;
        done_q <= 1'b1;
      end
    end else if (done_q && !scl_s_i) begin
      sda_o <= sda_next_i;
    end
  end

  assert_high_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_s_i |=> $stable(sda_o));
  assert_zero_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && hold_i == '0) |=> (sda_o == $past(sda_next_i)));
  assert_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > TX_W'(1) && !fall_i && !rise_i) |=> $stable(sda_o));
endmodule

// File: rtl/sda_hold_gen.sv
module sda_hold_gen
  import sda_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_next_i,
  input  logic             is_tx_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             sda_o,
  output logic             cfg_err_o
);
  logic             scl_s, fall, rise, valid;
  logic [LEN_W-1:0] low_len;
  logic [TX_W-1:0]  hold;

  sda_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i,
    .scl_s_o(scl_s), .fall_o(fall), .rise_o(rise)
  );

  sda_low_meter u_meter (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .fall_i(fall), .rise_i(rise),
    .low_len_o(low_len), .valid_o(valid)
  );

  sda_hold_sel u_sel (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_i, .is_tx_i,
    .low_len_i(low_len), .valid_i(valid),
    .cfg_o, .hold_o(hold), .err_o(cfg_err_o)
  );

  sda_hold_ctrl u_ctrl (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .fall_i(fall), .rise_i(rise),
    .hold_i(hold), .sda_next_i, .sda_o
  );
endmodule

// File: tb/sim_sda_hold_gen.sv
module sim_sda_hold_gen;
  logic        clk = 0, rst_n = 0;
  logic        scl = 1, nxt = 1, is_tx = 1, we = 0;
  logic [31:0] cfg_w = '0, cfg_r;
  logic        sda, err;
  int checks = 0, errors = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  sda_hold_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_next_i(nxt),
    .is_tx_i(is_tx), .cfg_we_i(we), .cfg_i(cfg_w),
    .cfg_o(cfg_r), .sda_o(sda), .cfg_err_o(err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cfg(logic [31:0] v);
    cfg_w = v; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic go_high(int n);
    scl = 1;
    repeat (n) @(negedge clk);
  endtask

  // drive SCL low with new data; expect sda to move after hold h
  task automatic low_phase(string req, logic v, int h, int total);
    logic old = sda;
    scl = 0; nxt = v;
    step(h + 2);
    chk(req, sda, old);
    step(1);
    chk(req, sda, v);
    repeat (total - (h + 3)) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", cfg_r, 32'h0000_0001);
    chk("R6", sda, 1);
    chk("R8", err, 0);
  endtask

  task automatic t_cfg;
    wr_cfg(32'hAB07_0005);
    chk("R2", cfg_r, 32'h0007_0005);
    nxt = 0; // while SCL high, must not propagate
    step(3);
    chk("R6", sda, 1);
  endtask

  task automatic t_tx;
    is_tx = 1;
    low_phase("R3", 0, 5, 40);
    go_high(10);
    low_phase("R3", 1, 5, 40);
    go_high(10);
  endtask

  task automatic t_follow;
    scl = 0; nxt = 0;
    step(8);
    chk("R3", sda, 0);
    nxt = 1; step(1);
    chk("R7", sda, 1);
    nxt = 0; step(1);
    chk("R7", sda, 0);
    repeat (20) @(negedge clk);
    go_high(5);
    nxt = 1; step(4);
    chk("R6", sda, 0);
    go_high(5);
  endtask

  task automatic t_rx;
    is_tx = 0;
    low_phase("R4", 1, 7, 40);
    go_high(10);
    is_tx = 1;
  endtask

  task automatic t_zero;
    wr_cfg(32'h0007_0000);
    low_phase("R5", 0, 0, 40);
    go_high(10);
  endtask

  task automatic t_clamp;
    scl = 0; repeat (6) @(negedge clk);
    go_high(10);
    wr_cfg(32'h0000_000A);
    chk("R8", err, 1);
    low_phase("R8", 1, 4, 30);
    go_high(10);
    wr_cfg(32'h0000_001C);
    chk("R9", err, 0);
    low_phase("R9", 0, 28, 40);
    go_high(10);
    wr_cfg(32'h0000_0027);
    chk("R8", err, 1);
  endtask

  initial begin
    #200000;
    if (!fin) begin
      fin = 1; errors++; checks++;
      $display("FAIL watchdog");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_cfg;
    t_tx;
    t_follow;
    t_rx;
    t_zero;
    t_clamp;
    if (!fin) begin
      fin = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule